// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block forms data-memory addresses for a small 8-bit processor and holds the byte storage behind them. The data space has 4096 bytes, split into sixteen banks of 256. Every access carries an 8-bit offset and a one-bit mode flag. With the flag set, the bank comes from a 4-bit bank register. With the flag clear, the offset indexes a fixed 256-byte window. That window joins the bottom 128 bytes of bank 0 to the top 128 bytes of bank 15, so common variables and the control registers can be reached without reprogramming the bank.

The top 128 bytes of the space (0xF80 to 0xFFF) hold the control registers. These live outside the block and are reached through a simple register bus. Every other byte is kept in an internal synchronous RAM. The unit has one read port and one write port, and both may be used in the same cycle. Read data returns one cycle after the request, with a valid strobe, whether the byte came from RAM or from the register bus.

Top module: `bdm_unit`

## Requirements
- R1: With `rd_acc`/`wr_acc` = 1 (banked mode), the access targets address {bsr_q, offset}.
- R2: With the mode flag = 0 and an offset in 0x00 to 0x7F, the access targets address 0x000 + offset in bank 0, whatever the bank register holds.
- R3: With the mode flag = 0 and an offset in 0x80 to 0xFF, the access targets address 0xF00 + offset, so offset 0x80 directly follows offset 0x7F in one contiguous window.
- R4: `bsr_q` is 0 after reset, takes `bsr_wdata` on the clock edge where `bsr_we` is 1, and otherwise holds. An access issued in the same cycle as a bank write still uses the old bank.
- R5: An access whose address lies in 0xF80 to 0xFFF raises `reg_rd_en` or `reg_wr_en` in the same cycle, with the low 7 address bits on `reg_raddr`/`reg_waddr` and the write byte on `reg_wdata`. Such a write leaves the RAM unchanged. Any other address raises neither strobe.
- R6: A RAM read returns the last byte written to that address on `rd_data`, one cycle after the request.
- R7: A register-region read returns on `rd_data`, one cycle after the request, the `reg_rdata` value presented in the request cycle.
- R8: A read and a write to the same RAM address in the same cycle return the byte held before the write. The new byte is returned by the next read.
- R9: In window mode, an offset of 0x80 or above always reaches the register bus, for any bank register value.
- R10: `rd_valid` is 1 exactly in the cycle after a cycle with `rd_en` = 1, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bsr_we | input | 1 | Bank register write strobe |
| bsr_wdata | input | 4 | New bank number |
| bsr_q | output | 4 | Current bank number |
| rd_en | input | 1 | Read request |
| rd_acc | input | 1 | Read mode flag: 0 window, 1 banked |
| rd_ofs | input | 8 | Read file offset |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read data |
| wr_en | input | 1 | Write request |
| wr_acc | input | 1 | Write mode flag: 0 window, 1 banked |
| wr_ofs | input | 8 | Write file offset |
| wr_data | input | 8 | Write data |
| reg_rd_en | output | 1 | Register bus read strobe |
| reg_raddr | output | 7 | Register bus read index |
| reg_rdata | input | 8 | Register bus read data, valid in the strobe cycle |
| reg_wr_en | output | 1 | Register bus write strobe |
| reg_waddr | output | 7 | Register bus write index |
| reg_wdata | output | 8 | Register bus write data |

## Verification
The assertions assume that the mode flags and offsets are stable and known whenever their enable is high. They also assume that the register bus returns `reg_rdata` in the same cycle as the strobe, with no wait states. The bench drives every input at the falling edge, holds it for a full cycle, and models the register bus as a fixed function of the read index, so both assumptions hold. In the random phase, reads of RAM bytes that were never written are issued but not compared, because their content is undefined.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

   // mode flag carried with every access
   typedef enum logic {
      ACC_WINDOW = 1'b0,
      ACC_BANKED = 1'b1
   } acc_mode_e;

   // port indices for the per-port address mapping
   localparam int PORT_RD = 0;
   localparam int PORT_WR = 1;
   localparam int N_PORTS = 2;

endpackage

// File: rtl/bdm_bank_reg.sv
module bdm_bank_reg #(
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we) q <= wdata;
   end

   // R4
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

   // R4
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q == $past(wdata));

endmodule

// File: rtl/bdm_addr_map.sv
module bdm_addr_map
   import bdm_pkg::*;
#(
   parameter int BANK_W = 4,
   parameter int OFS_W  = 8,
   parameter int ADDR_W = BANK_W + OFS_W,
   parameter int SFR_W  = OFS_W - 1
) (
   input  logic              acc,
   input  logic [BANK_W-1:0] bsr,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] addr,
   output logic              is_sfr,
   output logic [SFR_W-1:0]  sfr_idx
);

   localparam int TOP_W = ADDR_W - SFR_W;

   always_comb begin
      if (acc == ACC_BANKED)
         addr = {bsr, ofs};
      else if (!ofs[OFS_W-1])
         addr = {{BANK_W{1'b0}}, ofs};
      else
         addr = {{BANK_W{1'b1}}, ofs};
   end

   always_comb begin
      is_sfr  = &addr[ADDR_W-1 -: TOP_W];
      sfr_idx = addr[SFR_W-1:0];
   end

endmodule

// File: rtl/bdm_ram.sv
module bdm_ram #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 3968
) (
   input  logic              clk,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   // both updates are nonblocking, so a read sees the pre-write byte
   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
      if (we) mem[waddr] <= wdata;
   end

endmodule

// File: rtl/bdm_unit.sv
module bdm_unit
   import bdm_pkg::*;
#(
   parameter int BANK_W = 4,
   parameter int OFS_W  = 8,
   parameter int DATA_W = 8,
   parameter int ADDR_W = BANK_W + OFS_W,
   parameter int SFR_W  = OFS_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bsr_we,
   input  logic [BANK_W-1:0] bsr_wdata,
   output logic [BANK_W-1:0] bsr_q,
   input  logic              rd_en,
   input  logic              rd_acc,
   input  logic [OFS_W-1:0]  rd_ofs,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic              wr_acc,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic [DATA_W-1:0] wr_data,
   output logic              reg_rd_en,
   output logic [SFR_W-1:0]  reg_raddr,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              reg_wr_en,
   output logic [SFR_W-1:0]  reg_waddr,
   output logic [DATA_W-1:0] reg_wdata
);

   localparam int RAM_DEPTH = (1 << ADDR_W) - (1 << SFR_W);

   if (BANK_W < 1) begin : g_bad_bank
      $error("BANK_W must be at least 1");
   end
   if (OFS_W < 2) begin : g_bad_ofs
      $error("OFS_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (ADDR_W != BANK_W + OFS_W) begin : g_bad_addr
      $error("ADDR_W must equal BANK_W + OFS_W");
   end
   if (SFR_W != OFS_W - 1) begin : g_bad_sfr
      $error("register region must be the upper half of the last bank");
   end

   // ---------------- bank register ----------------
   bdm_bank_reg #(.BANK_W(BANK_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bsr_we),
      .wdata (bsr_wdata),
      .q     (bsr_q)
   );

   // ---------------- per-port address mapping ----------------
   logic               p_acc  [N_PORTS];
   logic [OFS_W-1:0]   p_ofs  [N_PORTS];
   logic [ADDR_W-1:0]  p_addr [N_PORTS];
   logic               p_sfr  [N_PORTS];
   logic [SFR_W-1:0]   p_idx  [N_PORTS];

   assign p_acc[PORT_RD] = rd_acc;
   assign p_ofs[PORT_RD] = rd_ofs;
   assign p_acc[PORT_WR] = wr_acc;
   assign p_ofs[PORT_WR] = wr_ofs;

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      bdm_addr_map #(
         .BANK_W (BANK_W),
         .OFS_W  (OFS_W),
         .ADDR_W (ADDR_W),
         .SFR_W  (SFR_W)
      ) u_map (
         .acc     (p_acc[p]),
         .bsr     (bsr_q),
         .ofs     (p_ofs[p]),
         .addr    (p_addr[p]),
         .is_sfr  (p_sfr[p]),
         .sfr_idx (p_idx[p])
      );
   end

   // ---------------- routing ----------------
   logic ram_re, ram_we;
   logic [DATA_W-1:0] ram_q;

   always_comb begin
      ram_re    = rd_en && !p_sfr[PORT_RD];
      ram_we    = wr_en && !p_sfr[PORT_WR];
      reg_rd_en = rd_en &&  p_sfr[PORT_RD];
      reg_wr_en = wr_en &&  p_sfr[PORT_WR];
      reg_raddr = p_idx[PORT_RD];
      reg_waddr = p_idx[PORT_WR];
      reg_wdata = wr_data;
   end

   bdm_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (RAM_DEPTH)
   ) u_ram (
      .clk   (clk),
      .re    (ram_re),
      .raddr (p_addr[PORT_RD]),
      .rdata (ram_q),
      .we    (ram_we),
      .waddr (p_addr[PORT_WR]),
      .wdata (wr_data)
   );

   // ---------------- read return stage ----------------
   logic              rsel_reg_q;
   logic [DATA_W-1:0] reg_cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rsel_reg_q <= 1'b0;
         reg_cap_q  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rsel_reg_q <= p_sfr[PORT_RD];
         if (reg_rd_en) reg_cap_q <= reg_rdata;
      end
   end

   assign rd_data = rsel_reg_q ? reg_cap_q : ram_q;

   // ---------------- assertions ----------------
   // R10
   rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R10
   rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R9
   win_high_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_acc == ACC_WINDOW && rd_ofs[OFS_W-1]) |-> reg_rd_en);

   // R2
   win_low_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_acc == ACC_WINDOW && !wr_ofs[OFS_W-1]) |-> !reg_wr_en);

   // R5
   reg_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (wr_en && !ram_we));

   // R7
   reg_rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> (rd_valid && rd_data == $past(reg_rdata)));

endmodule

// File: tb/test_bdm_unit.sv
`timescale 1ns/1ps
module test_bdm_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bsr_we = 1'b0;
   logic [3:0] bsr_wdata = '0;
   logic [3:0] bsr_q;
   logic       rd_en = 1'b0, rd_acc = 1'b0;
   logic [7:0] rd_ofs = '0;
   logic       rd_valid;
   logic [7:0] rd_data;
   logic       wr_en = 1'b0, wr_acc = 1'b0;
   logic [7:0] wr_ofs = '0, wr_data = '0;
   logic       reg_rd_en, reg_wr_en;
   logic [6:0] reg_raddr, reg_waddr;
   logic [7:0] reg_rdata, reg_wdata;

   always #4 clk = ~clk;

   function automatic [7:0] reg_val(input [6:0] a);
      return {a[3:0], a[6:3]} ^ 8'hC3;
   endfunction

   assign reg_rdata = reg_val(reg_raddr);

   bdm_unit i_bdm_unit (
      .clk(clk), .rst_n(rst_n),
      .bsr_we(bsr_we), .bsr_wdata(bsr_wdata), .bsr_q(bsr_q),
      .rd_en(rd_en), .rd_acc(rd_acc), .rd_ofs(rd_ofs),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_en(wr_en), .wr_acc(wr_acc), .wr_ofs(wr_ofs), .wr_data(wr_data),
      .reg_rd_en(reg_rd_en), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .reg_wr_en(reg_wr_en), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   typedef struct {
      bit         cmp;
      logic [7:0] val;
      int         req;
   } exp_t;
   exp_t sb[$];

   logic [7:0] mdl [4096];
   bit         mdl_ok [4096];
   logic [3:0] bsr_m = '0;

   task automatic check(input bit ok, input int req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // address formed from the requirement text (R1, R2, R3)
   function automatic [11:0] map_addr(input bit acc, input [7:0] ofs, input [3:0] b);
      if (acc) return {b, ofs};
      if (ofs < 8'h80) return 12'h000 + ofs;
      return 12'hF00 + ofs;
   endfunction

   // one bus cycle; rq is the tag of the requirement the read exercises
   task automatic cyc(input bit re, input bit ra, input [7:0] ro,
                      input bit we, input bit wa, input [7:0] wo, input [7:0] wd,
                      input bit bw, input [3:0] bd, input int rq);
      logic [11:0] a_r, a_w;
      exp_t e;
      @(negedge clk);
      rd_en = re; rd_acc = ra; rd_ofs = ro;
      wr_en = we; wr_acc = wa; wr_ofs = wo; wr_data = wd;
      bsr_we = bw; bsr_wdata = bd;
      #1;
      a_r = map_addr(ra, ro, bsr_m);
      a_w = map_addr(wa, wo, bsr_m);
      // R4 bank register value
      check(bsr_q == bsr_m, 4, "bank register", bsr_q, bsr_m);
      // R5 register bus read strobe and index
      check(reg_rd_en == (re && a_r >= 12'hF80), 5, "reg read strobe",
            reg_rd_en, re && a_r >= 12'hF80);
      if (re && a_r >= 12'hF80)
         check(reg_raddr == a_r[6:0], 5, "reg read index", reg_raddr, a_r[6:0]);
      // R5 register bus write strobe, index, data
      check(reg_wr_en == (we && a_w >= 12'hF80), 5, "reg write strobe",
            reg_wr_en, we && a_w >= 12'hF80);
      if (we && a_w >= 12'hF80)
         check(reg_waddr == a_w[6:0] && reg_wdata == wd, 5, "reg write index/data",
               {reg_waddr, reg_wdata}, {a_w[6:0], wd});
      if (re) begin
         e.req = rq;
         if (a_r >= 12'hF80) begin
            e.cmp = 1; e.val = reg_val(a_r[6:0]);
         end else begin
            e.cmp = mdl_ok[a_r]; e.val = mdl[a_r];
         end
         sb.push_back(e);
      end
      if (we && a_w < 12'hF80) begin
         mdl[a_w] = wd; mdl_ok[a_w] = 1;
      end
      if (bw) bsr_m = bd;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   // monitor: pops the scoreboard when the design returns data
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb.size() == 0) begin
            check(0, 10, "unexpected rd_valid", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.cmp) check(rd_data == e.val, e.req, "read data", rd_data, e.val);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4096; i++) mdl_ok[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      // R4 and R10 reset state
      check(bsr_q == 4'h0, 4, "bank after reset", bsr_q, 0);
      check(rd_valid == 1'b0, 10, "rd_valid in reset", rd_valid, 0);
      @(negedge clk); rst_n = 1;

      // R2: banked bank 0 write, window low read
      cyc(0, 0, 0, 1, 1, 8'h10, 8'hA1, 0, 0, 2);
      cyc(1, 0, 8'h10, 0, 0, 0, 0, 0, 0, 2);
      // R2: window low write, later read in banked mode
      cyc(0, 0, 0, 1, 0, 8'h7F, 8'h77, 0, 0, 2);
      // R1: move to bank 5
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 4'h5, 1);
      cyc(0, 0, 0, 1, 1, 8'h33, 8'h55, 0, 0, 1);
      cyc(1, 1, 8'h33, 0, 0, 0, 0, 0, 0, 1);
      // R2: window low ignores bank 5
      cyc(1, 0, 8'h7F, 0, 0, 0, 0, 0, 0, 2);
      // R3 / R9: window high reaches registers while bank is 5
      cyc(1, 0, 8'h80, 1, 0, 8'h80, 8'h99, 0, 0, 9);
      cyc(1, 0, 8'hFF, 0, 0, 0, 0, 0, 0, 7);
      // R8: read and write same address same cycle -> old byte
      cyc(1, 1, 8'h33, 1, 1, 8'h33, 8'h11, 0, 0, 8);
      cyc(1, 1, 8'h33, 0, 0, 0, 0, 0, 0, 8);
      // R4: read issued with a bank write uses the old bank
      cyc(1, 1, 8'h33, 0, 0, 0, 0, 1, 4'h3, 4);
      // R3: bank 3 offset 0x80 is RAM in banked mode, registers in window mode
      cyc(0, 0, 0, 1, 1, 8'h80, 8'h3C, 0, 0, 3);
      cyc(1, 1, 8'h80, 0, 0, 0, 0, 0, 0, 6);
      cyc(1, 0, 8'h80, 0, 0, 0, 0, 0, 0, 3);
      // R1 / R6: bank 15 below the register region is RAM
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 4'hF, 1);
      cyc(0, 0, 0, 1, 1, 8'h7E, 8'hE7, 0, 0, 6);
      cyc(1, 1, 8'h7E, 0, 0, 0, 0, 0, 0, 6);
      cyc(1, 1, 8'hC5, 1, 1, 8'hC5, 8'h42, 0, 0, 7);
      // R2: bank 0 byte back through banked mode
      cyc(1, 1, 8'h7F, 0, 0, 0, 0, 1, 4'h0, 2);
      cyc(1, 1, 8'h7F, 0, 0, 0, 0, 0, 0, 2);
      idle();

      // random phase covering R1, R3, R6, R8
      for (int k = 0; k < 600; k++) begin
         bit re_r, we_r, bw_r, ra_r, wa_r;
         logic [7:0] ro_r, wo_r;
         re_r = 1'($urandom_range(0, 1));
         we_r = 1'($urandom_range(0, 1));
         bw_r = ($urandom_range(0, 7) == 0);
         ra_r = 1'($urandom_range(0, 1));
         wa_r = 1'($urandom_range(0, 1));
         ro_r = 8'($urandom_range(0, 255));
         wo_r = ($urandom_range(0, 3) == 0) ? ro_r : 8'($urandom_range(0, 255));
         cyc(re_r, ra_r, ro_r, we_r, wa_r, wo_r, 8'($urandom_range(0, 255)),
             bw_r, 4'($urandom_range(0, 15)), 6);
      end
      idle();
      idle();
      // R10: every request answered exactly once
      check(sb.size() == 0, 10, "outstanding reads", sb.size(), 0);

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule